// File: doc/BRIEF.md
# Object Handle Hash Table Engine

This block keeps a table of 32-bit object handles in a synchronous single-port RAM. Each table entry takes two 32-bit words: the handle itself and a packed context word that records the instance address, the engine number and the channel that owns the handle. A client issues one of four commands: insert, lookup, remove or clear. The block answers with a one-cycle done pulse, a status code, the context word and the byte offset of the entry.

The table index comes from a hash. The handle is XOR-folded down to the index width, and the channel number is mixed in at a fixed shift. Collisions are resolved by linear probing, which wraps from the last entry to the first. An all-zero handle word marks a free entry. A single input selects one of two context-word layouts when an entry is written. The table RAM sits outside the block, on a plain address/enable/write port with one cycle of read latency.

The controller is one state machine with these states:
- IDLE: waits for a command.
- PROBE: issues the first handle read.
- CHECK_HANDLE: examines a handle word, then writes it, reads its context word, or reads the next handle.
- CHECK_CONTEXT: compares the stored channel.
- WRITE_CONTEXT: writes the new context word.
- WRITE_ZERO: clears the context word of a removed entry.
- CLEAR: zeroes every RAM word.
- DONE: holds the result for one cycle.

The transitions are:
- IDLE to PROBE on a command.
- IDLE to CLEAR on a clear command.
- IDLE to DONE on a command with a zero handle.
- PROBE to CHECK_HANDLE.
- CHECK_HANDLE stays in CHECK_HANDLE to advance to the next entry.
- CHECK_HANDLE to WRITE_CONTEXT when an insert finds a free entry.
- CHECK_HANDLE to CHECK_CONTEXT when the handle matches.
- CHECK_HANDLE to DONE on a free entry (lookup or remove) or on a full wrap.
- CHECK_CONTEXT to WRITE_ZERO when a remove hits.
- CHECK_CONTEXT to DONE on a lookup hit or on a wrap.
- CHECK_CONTEXT to CHECK_HANDLE when the channel differs.
- WRITE_CONTEXT, WRITE_ZERO and CLEAR (after the last word) to DONE.
- DONE to IDLE.

Top module: `ohash_engine`

## Requirements
- R1: The home index is formed in two steps. First, the 32-bit handle is cut into HT_BITS-wide chunks, starting at bit 0 and zero-filling the top chunk, and the chunks are XORed together. Then the 5-bit channel, shifted left by HT_BITS-4, is XORed in and the result is truncated to HT_BITS bits.
- R2: With fmt_new low, the context word is laid out as follows: instance in bits 15:0, engine in bits 17:16, channel in bits 28:24, bit 31 set to 1, and every other bit 0.
- R3: With fmt_new high, the context word is laid out as follows: instance in bits 19:0, engine in bits 21:20, channel in bits 28:24, bit 31 set to 0, and every other bit 0.
- R4: An insert probes entries home, home+1, and so on, modulo 2^HT_BITS. It writes the first entry whose handle word is zero and reports status 0 (ok) with rsp_slot equal to index*8.
- R5: An insert that finds all 2^HT_BITS entries occupied reports status 2 (full) and writes nothing. This takes HT_BITS-dependent time of 2^HT_BITS+2 cycles.
- R6: Lookup follows the same probe order as insert. It hits only where the stored handle equals the request and context bits 28:24 equal the channel, and then reports status 0 with the stored context word and the slot. It reports status 1 (not found) at the first zero handle word or after a full wrap.
- R7: A lookup, insert or remove with handle zero reports status 1 one cycle after acceptance, without any RAM access.
- R8: A remove that hits writes zero to both words of the entry and reports status 0 with the old context word. Because the entry becomes free, it ends later probe chains that passed through it.
- R9: A clear writes zero to all 2^(HT_BITS+1) RAM words and reports status 0.
- R10: Command encodings are 0 insert, 1 lookup, 2 remove, 3 clear. A command is taken when cmd_valid and cmd_ready are both high, and cmd_ready is high only in IDLE. rsp_done is high for exactly one cycle per command.
- R11: The handle word of entry i lives at RAM word address 2i and its context word at 2i+1. Read data is used one cycle after the read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle, command accepted this cycle if valid |
| cmd_op | input | 2 | 0 insert, 1 lookup, 2 remove, 3 clear |
| cmd_handle | input | 32 | Object handle |
| cmd_chan | input | 5 | Channel number |
| cmd_engine | input | 2 | Engine number for insert |
| cmd_inst | input | 20 | Instance address in 16-byte units for insert |
| fmt_new | input | 1 | Context-word layout select for insert |
| rsp_done | output | 1 | One-cycle result strobe |
| rsp_status | output | 2 | 0 ok, 1 not found, 2 full |
| rsp_ctx | output | 32 | Context word written, found or removed |
| rsp_slot | output | HT_BITS+3 | Byte offset of the entry (index*8) |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write when enabled, read otherwise |
| ram_addr | output | HT_BITS+1 | RAM word address |
| ram_wdata | output | 32 | RAM write data |
| ram_rdata | input | 32 | RAM read data, one cycle after a read |

## Verification
Latency is measured as the number of clock edges from the accepting edge up to and including the edge that raises rsp_done.
- Lookup and insert: an insert or a lookup hit at the home entry takes 4 cycles. Each extra occupied entry adds 1 cycle, and each handle match with the wrong channel adds 2.
- Remove: a remove hit takes one cycle more than a lookup hit.
- Other cases: a miss on a free entry takes 3 plus the probes; a zero handle takes 1; a full table takes 2^HT_BITS+2; a clear takes 2^(HT_BITS+1)+1.

The bench keeps its own shadow of the table and computes the status, slot, context word and this exact cycle count for every command. It counts falling edges after acceptance and samples outputs on the falling edge where rsp_done is first seen.

// File: rtl/ohash_pkg.sv
package ohash_pkg;
    localparam int HANDLE_W     = 32;
    localparam int WORD_W       = 32;
    localparam int CHAN_W       = 5;
    localparam int ENG_W        = 2;
    localparam int INST_W       = 20;
    localparam int CTX_CHAN_LSB = 24;

    typedef enum logic [1:0] {
        OP_INSERT = 2'd0,
        OP_LOOKUP = 2'd1,
        OP_REMOVE = 2'd2,
        OP_CLEAR  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_OK        = 2'd0,
        ST_NOT_FOUND = 2'd1,
        ST_FULL      = 2'd2
    } status_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PROBE,
        S_CHK_H,
        S_CHK_C,
        S_WR_C,
        S_WR_Z,
        S_CLR,
        S_DONE
    } state_e;
endpackage

// File: rtl/ohash_fold.sv
// Home index: XOR-fold of the handle in index-wide chunks, channel mixed in.
module ohash_fold
    import ohash_pkg::*;
#(
    parameter int HT_BITS = 9
) (
    input  logic [HANDLE_W-1:0] handle,
    input  logic [CHAN_W-1:0]   chan,
    output logic [HT_BITS-1:0]  index
);
    localparam int NCHUNK = (HANDLE_W + HT_BITS - 1) / HT_BITS;
    localparam int EXT_W  = NCHUNK * HT_BITS;
    localparam int MIX_W  = HT_BITS + CHAN_W;

    logic [EXT_W-1:0]   ext;
    logic [HT_BITS-1:0] folded;
    logic [MIX_W-1:0]   chan_mix;

    assign ext      = EXT_W'(handle);
    assign chan_mix = MIX_W'(chan) << (HT_BITS - 4);

    always_comb begin
        folded = '0;
        for (int i = 0; i < NCHUNK; i++) begin
            folded = folded ^ ext[i*HT_BITS +: HT_BITS];
        end
    end

    assign index = folded ^ chan_mix[HT_BITS-1:0];
endmodule

// File: rtl/ohash_ctx_pack.sv
// Builds the context word in one of two layouts.
module ohash_ctx_pack
    import ohash_pkg::*;
(
    input  logic              fmt_new,
    input  logic [CHAN_W-1:0] chan,
    input  logic [ENG_W-1:0]  engine,
    input  logic [INST_W-1:0] inst,
    output logic [WORD_W-1:0] ctx
);
    logic [WORD_W-1:0] ctx_legacy;
    logic [WORD_W-1:0] ctx_wide;

    // legacy: valid flag 31, channel 28:24, engine 17:16, instance 15:0
    assign ctx_legacy = {1'b1, 2'b00, chan, 6'b000000, engine, inst[15:0]};
    // wide: channel 28:24, engine 21:20, instance 19:0, no valid flag
    assign ctx_wide   = {3'b000, chan, 2'b00, engine, inst};

    assign ctx = fmt_new ? ctx_wide : ctx_legacy;
endmodule

// File: rtl/ohash_engine.sv
module ohash_engine
    import ohash_pkg::*;
#(
    parameter int HT_BITS = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    output logic                 cmd_ready,
    input  logic [1:0]           cmd_op,
    input  logic [HANDLE_W-1:0]  cmd_handle,
    input  logic [CHAN_W-1:0]    cmd_chan,
    input  logic [ENG_W-1:0]     cmd_engine,
    input  logic [INST_W-1:0]    cmd_inst,
    input  logic                 fmt_new,
    output logic                 rsp_done,
    output logic [1:0]           rsp_status,
    output logic [WORD_W-1:0]    rsp_ctx,
    output logic [HT_BITS+2:0]   rsp_slot,
    output logic                 ram_en,
    output logic                 ram_we,
    output logic [HT_BITS:0]     ram_addr,
    output logic [WORD_W-1:0]    ram_wdata,
    input  logic [WORD_W-1:0]    ram_rdata
);
    localparam int ADDR_W = HT_BITS + 1;
    localparam int SLOT_W = HT_BITS + 3;

    state_e              state_q, state_d;
    op_e                 op_q;
    logic [HANDLE_W-1:0] handle_q;
    logic [CHAN_W-1:0]   chan_q;
    logic [WORD_W-1:0]   ctx_q;
    logic [HT_BITS-1:0]  start_q, idx_q, idx_nxt;
    logic [ADDR_W-1:0]   clr_q;

    status_e             res_status_q, res_status_d;
    logic [WORD_W-1:0]   res_ctx_q, res_ctx_d;
    logic [SLOT_W-1:0]   res_slot_q, res_slot_d;
    logic                res_set, idx_adv, clr_adv;

    logic [HT_BITS-1:0]  home_idx;
    logic [WORD_W-1:0]   new_ctx;
    logic                wrap;
    logic                accept;
    logic [CHAN_W-1:0]   stored_chan;
    logic [SLOT_W-1:0]   cur_slot;

    ohash_fold #(.HT_BITS(HT_BITS)) u_fold (
        .handle (cmd_handle),
        .chan   (cmd_chan),
        .index  (home_idx)
    );

    ohash_ctx_pack u_pack (
        .fmt_new (fmt_new),
        .chan    (cmd_chan),
        .engine  (cmd_engine),
        .inst    (cmd_inst),
        .ctx     (new_ctx)
    );

    assign idx_nxt     = idx_q + 1'b1;
    assign wrap        = (idx_nxt == start_q);
    assign accept      = cmd_valid && (state_q == S_IDLE);
    assign stored_chan = ram_rdata[CTX_CHAN_LSB +: CHAN_W];
    assign cur_slot    = {idx_q, 3'b000};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // command and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q         <= OP_LOOKUP;
            handle_q     <= '0;
            chan_q       <= '0;
            ctx_q        <= '0;
            start_q      <= '0;
            idx_q        <= '0;
            clr_q        <= '0;
            res_status_q <= ST_OK;
            res_ctx_q    <= '0;
            res_slot_q   <= '0;
        end else begin
            if (accept) begin
                op_q     <= op_e'(cmd_op);
                handle_q <= cmd_handle;
                chan_q   <= cmd_chan;
                ctx_q    <= new_ctx;
                start_q  <= home_idx;
                idx_q    <= home_idx;
                clr_q    <= '0;
            end
            if (idx_adv) begin
                idx_q <= idx_nxt;
            end
            if (clr_adv) begin
                clr_q <= clr_q + 1'b1;
            end
            if (res_set) begin
                res_status_q <= res_status_d;
                res_ctx_q    <= res_ctx_d;
                res_slot_q   <= res_slot_d;
            end
        end
    end

    // next state, RAM access and result capture
    always_comb begin
        state_d      = state_q;
        idx_adv      = 1'b0;
        clr_adv      = 1'b0;
        res_set      = 1'b0;
        res_status_d = ST_OK;
        res_ctx_d    = '0;
        res_slot_d   = '0;
        ram_en       = 1'b0;
        ram_we       = 1'b0;
        ram_addr     = '0;
        ram_wdata    = '0;
        unique case (state_q)
            S_IDLE: begin
                if (cmd_valid) begin
                    if (op_e'(cmd_op) == OP_CLEAR) begin
                        state_d = S_CLR;
                    end else if (cmd_handle == '0) begin
                        state_d      = S_DONE;
                        res_set      = 1'b1;
                        res_status_d = ST_NOT_FOUND;
                    end else begin
                        state_d = S_PROBE;
                    end
                end
            end
            S_PROBE: begin
                ram_en   = 1'b1;
                ram_addr = {idx_q, 1'b0};
                state_d  = S_CHK_H;
            end
            S_CHK_H: begin
                if (op_q == OP_INSERT) begin
                    if (ram_rdata == '0) begin
                        ram_en    = 1'b1;
                        ram_we    = 1'b1;
                        ram_addr  = {idx_q, 1'b0};
                        ram_wdata = handle_q;
                        state_d   = S_WR_C;
                    end else if (wrap) begin
                        state_d      = S_DONE;
                        res_set      = 1'b1;
                        res_status_d = ST_FULL;
                    end else begin
                        ram_en   = 1'b1;
                        ram_addr = {idx_nxt, 1'b0};
                        idx_adv  = 1'b1;
                    end
                end else begin
                    if (ram_rdata == '0) begin
                        state_d      = S_DONE;
                        res_set      = 1'b1;
                        res_status_d = ST_NOT_FOUND;
                    end else if (ram_rdata == handle_q) begin
                        ram_en   = 1'b1;
                        ram_addr = {idx_q, 1'b1};
                        state_d  = S_CHK_C;
                    end else if (wrap) begin
                        state_d      = S_DONE;
                        res_set      = 1'b1;
                        res_status_d = ST_NOT_FOUND;
                    end else begin
                        ram_en   = 1'b1;
                        ram_addr = {idx_nxt, 1'b0};
                        idx_adv  = 1'b1;
                    end
                end
            end
            S_CHK_C: begin
                if (stored_chan == chan_q) begin
                    res_set      = 1'b1;
                    res_status_d = ST_OK;
                    res_ctx_d    = ram_rdata;
                    res_slot_d   = cur_slot;
                    if (op_q == OP_REMOVE) begin
                        ram_en   = 1'b1;
                        ram_we   = 1'b1;
                        ram_addr = {idx_q, 1'b0};
                        state_d  = S_WR_Z;
                    end else begin
                        state_d = S_DONE;
                    end
                end else if (wrap) begin
                    state_d      = S_DONE;
                    res_set      = 1'b1;
                    res_status_d = ST_NOT_FOUND;
                end else begin
                    ram_en   = 1'b1;
                    ram_addr = {idx_nxt, 1'b0};
                    idx_adv  = 1'b1;
                    state_d  = S_CHK_H;
                end
            end
            S_WR_C: begin
                ram_en       = 1'b1;
                ram_we       = 1'b1;
                ram_addr     = {idx_q, 1'b1};
                ram_wdata    = ctx_q;
                state_d      = S_DONE;
                res_set      = 1'b1;
                res_status_d = ST_OK;
                res_ctx_d    = ctx_q;
                res_slot_d   = cur_slot;
            end
            S_WR_Z: begin
                ram_en   = 1'b1;
                ram_we   = 1'b1;
                ram_addr = {idx_q, 1'b1};
                state_d  = S_DONE;
            end
            S_CLR: begin
                ram_en   = 1'b1;
                ram_we   = 1'b1;
                ram_addr = clr_q;
                clr_adv  = 1'b1;
                if (&clr_q) begin
                    state_d      = S_DONE;
                    res_set      = 1'b1;
                    res_status_d = ST_OK;
                end
            end
            S_DONE: begin
                state_d = S_IDLE;
            end
            default: begin
                state_d = S_IDLE;
            end
        endcase
    end

    // outputs
    assign cmd_ready  = (state_q == S_IDLE);
    assign rsp_done   = (state_q == S_DONE);
    assign rsp_status = res_status_q;
    assign rsp_ctx    = res_ctx_q;
    assign rsp_slot   = res_slot_q;

    // R10: result strobe lasts one cycle and the engine is idle right after
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> (!rsp_done && cmd_ready));

    // R7: zero handle answered on the next cycle with not-found
    p_zero_handle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && (cmd_op != 2'd3) && (cmd_handle == '0))
        |=> (rsp_done && (rsp_status == 2'd1)));

    // R5: only an insert can report a full table
    p_full_insert_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && (rsp_status == 2'd2)) |-> (op_q == OP_INSERT));

    // R4: a handle word is only written over an empty entry
    p_write_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_CHK_H) && ram_we) |-> (ram_rdata == '0));

    // R7: a zero-handle command never touches the RAM on its next cycle
    p_zero_no_ram_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && (cmd_op != 2'd3) && (cmd_handle == '0))
        |=> !ram_en);
endmodule

// File: tb/test_ohash_engine.sv
module test_ohash_engine;
    localparam int HB   = 5;
    localparam int N    = 1 << HB;
    localparam int NW   = 2 * N;
    localparam int SW   = HB + 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_valid = 1'b0;
    logic            cmd_ready;
    logic [1:0]      cmd_op = 2'd0;
    logic [31:0]     cmd_handle = '0;
    logic [4:0]      cmd_chan = '0;
    logic [1:0]      cmd_engine = '0;
    logic [19:0]     cmd_inst = '0;
    logic            fmt_new = 1'b0;
    logic            rsp_done;
    logic [1:0]      rsp_status;
    logic [31:0]     rsp_ctx;
    logic [SW-1:0]   rsp_slot;
    logic            ram_en, ram_we;
    logic [HB:0]     ram_addr;
    logic [31:0]     ram_wdata;
    logic [31:0]     ram_rdata = '0;

    logic [31:0]     mem [NW];
    logic [31:0]     sh_h [N];
    logic [31:0]     sh_c [N];

    int vectors = 0;
    int fails   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ohash_engine #(.HT_BITS(HB)) i_ohash_engine (
        .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_op, .cmd_handle,
        .cmd_chan, .cmd_engine, .cmd_inst, .fmt_new, .rsp_done,
        .rsp_status, .rsp_ctx, .rsp_slot, .ram_en, .ram_we, .ram_addr,
        .ram_wdata, .ram_rdata
    );

    // R11: synchronous RAM, one cycle read latency
    always @(posedge clk) begin
        if (ram_en) begin
            if (ram_we) mem[ram_addr] <= ram_wdata;
            else        ram_rdata     <= mem[ram_addr];
        end
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [HB-1:0] ref_hash(input logic [31:0] h, input logic [4:0] ch);
        logic [HB-1:0] f = '0;
        logic [31:0]   mix;
        for (int i = 0; i < 32; i += HB) f = f ^ HB'(h >> i);
        mix = 32'(ch) << (HB - 4);
        return f ^ mix[HB-1:0];
    endfunction

    function automatic logic [31:0] ref_ctx(input logic fm, input logic [4:0] ch,
                                            input logic [1:0] eg, input logic [19:0] in);
        if (fm) return {3'b000, ch, 2'b00, eg, in};
        return {1'b1, 2'b00, ch, 6'b000000, eg, in[15:0]};
    endfunction

    task automatic run(input logic [1:0] op, input logic [31:0] h, input logic [4:0] ch,
                       input logic [1:0] eg, input logic [19:0] in, input logic fm,
                       output logic [1:0] st, output logic [31:0] cx,
                       output logic [SW-1:0] sl, output int lat);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_handle = h; cmd_chan = ch;
        cmd_engine = eg; cmd_inst = in; fmt_new = fm;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        lat = 1;
        while (!rsp_done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        if (!rsp_done) begin
            vectors++; fails++;
            $display("FAIL R10: no done, got lat %0d expected done", lat);
        end
        st = rsp_status; cx = rsp_ctx; sl = rsp_slot;
    endtask

    task automatic model_insert(input logic [31:0] h, input logic [4:0] ch, input logic [1:0] eg,
                                input logic [19:0] in, input logic fm,
                                output logic [1:0] st, output logic [31:0] cx,
                                output logic [SW-1:0] sl, output int lat);
        int idx = int'(ref_hash(h, ch));
        int t = 2;
        bit found = 1'b0;
        st = 2'd2; cx = '0; sl = '0;
        if (h == 0) begin st = 2'd1; lat = 1; return; end
        for (int k = 0; k < N; k++) begin
            if (!found) begin
                if (sh_h[idx] == 0) begin
                    found = 1'b1;
                    sh_h[idx] = h; sh_c[idx] = ref_ctx(fm, ch, eg, in);
                    st = 2'd0; cx = sh_c[idx]; sl = SW'(idx * 8); lat = t + 2;
                end else begin
                    idx = (idx + 1) % N; t++;
                end
            end
        end
        if (!found) lat = t;
    endtask

    task automatic model_find(input logic [31:0] h, input logic [4:0] ch, input bit rem,
                              output logic [1:0] st, output logic [31:0] cx,
                              output logic [SW-1:0] sl, output int lat);
        int idx = int'(ref_hash(h, ch));
        int t = 2;
        bit done = 1'b0;
        st = 2'd1; cx = '0; sl = '0;
        if (h == 0) begin lat = 1; return; end
        for (int k = 0; k < N; k++) begin
            if (!done) begin
                if (sh_h[idx] == 0) begin
                    done = 1'b1; lat = t + 1;
                end else if (sh_h[idx] == h) begin
                    if (sh_c[idx][28:24] == ch) begin
                        done = 1'b1; st = 2'd0; cx = sh_c[idx]; sl = SW'(idx * 8);
                        lat = rem ? t + 3 : t + 2;
                        if (rem) begin sh_h[idx] = '0; sh_c[idx] = '0; end
                    end else begin
                        t += 2;
                    end
                end else begin
                    t++;
                end
                idx = (idx + 1) % N;
            end
        end
        if (!done) lat = t;
    endtask

    task automatic compare(input string req, input logic [1:0] st, input logic [31:0] cx,
                           input logic [SW-1:0] sl, input int lat,
                           input logic [1:0] est, input logic [31:0] ecx,
                           input logic [SW-1:0] esl, input int elat);
        chk({req, " status"}, 32'(st), 32'(est));
        chk({req, " latency"}, 32'(lat), 32'(elat));
        if (est == 2'd0) begin
            chk({req, " slot"}, 32'(sl), 32'(esl));
            chk({req, " ctx"}, cx, ecx);
        end
    endtask

    task automatic chk_mem(input string req);
        for (int i = 0; i < N; i++) begin
            chk({req, " handle word"}, mem[2*i], sh_h[i]);
            chk({req, " ctx word"}, mem[2*i+1], sh_c[i]);
        end
    endtask

    task automatic ins(input string req, input logic [31:0] h, input logic [4:0] ch,
                       input logic [1:0] eg, input logic [19:0] in, input logic fm);
        logic [1:0] st, est; logic [31:0] cx, ecx; logic [SW-1:0] sl, esl; int lat, elat;
        model_insert(h, ch, eg, in, fm, est, ecx, esl, elat);
        run(2'd0, h, ch, eg, in, fm, st, cx, sl, lat);
        compare(req, st, cx, sl, lat, est, ecx, esl, elat);
    endtask

    task automatic find(input string req, input logic [31:0] h, input logic [4:0] ch, input bit rem);
        logic [1:0] st, est; logic [31:0] cx, ecx; logic [SW-1:0] sl, esl; int lat, elat;
        model_find(h, ch, rem, est, ecx, esl, elat);
        run(rem ? 2'd2 : 2'd1, h, ch, 2'd0, 20'd0, 1'b0, st, cx, sl, lat);
        compare(req, st, cx, sl, lat, est, ecx, esl, elat);
    endtask

    task automatic clear_all();
        logic [1:0] st; logic [31:0] cx; logic [SW-1:0] sl; int lat;
        run(2'd3, 32'd0, 5'd0, 2'd0, 20'd0, 1'b0, st, cx, sl, lat);
        chk("R9 clear status", 32'(st), 32'd0);
        chk("R9 clear latency", 32'(lat), 32'(NW + 1));
        for (int i = 0; i < N; i++) begin sh_h[i] = '0; sh_c[i] = '0; end
        chk_mem("R9 clear");
    endtask

    function automatic logic [31:0] fill_handle(input int i);
        return 32'h0001_0000 * 32'(i) + 32'(i * 7) + 32'd1;
    endfunction

    initial begin
        for (int i = 0; i < NW; i++) mem[i] = 32'hA5A5_0000 + 32'(i);
        for (int i = 0; i < N; i++) begin sh_h[i] = '0; sh_c[i] = '0; end
        repeat (3) @(negedge clk);
        // reset state (R10)
        chk("R10 reset ready", 32'(cmd_ready), 32'd1);
        chk("R10 reset done", 32'(rsp_done), 32'd0);
        chk("R11 reset ram idle", 32'(ram_en), 32'd0);
        rst_n = 1'b1;

        clear_all();

        // R7: zero handle for every non-clear command
        find("R7 zero lookup", 32'd0, 5'd3, 1'b0);
        find("R7 zero remove", 32'd0, 5'd1, 1'b1);
        ins("R7 zero insert", 32'd0, 5'd2, 2'd1, 20'h12345, 1'b0);
        chk_mem("R7 zero no write");

        // R1 R2 R3 R4: fill the whole table, both layouts
        for (int i = 0; i < N; i++) begin
            ins(i[0] ? "R3 R4 fill wide" : "R2 R4 fill legacy", fill_handle(i),
                5'(i % 4), 2'(i % 4), 20'h01200 + 20'(i * 2) + 20'hF0000 * 20'(i % 2), i[0]);
        end
        chk_mem("R4 R11 fill");
        // R5: no free entry
        ins("R5 full", 32'hCAFE_F00D, 5'd9, 2'd1, 20'd7, 1'b0);
        chk_mem("R5 full no write");

        // R6: hits, wrong channel and absent handle on a full table
        for (int i = 0; i < N; i++) find("R6 hit", fill_handle(i), 5'(i % 4), 1'b0);
        for (int i = 0; i < N; i += 5) find("R6 wrong chan", fill_handle(i), 5'(i % 4 + 4), 1'b0);
        find("R6 absent", 32'hDEAD_BEEF, 5'd0, 1'b0);

        // R8: removals then lookups
        for (int i = 0; i < N; i += 3) find("R8 remove", fill_handle(i), 5'(i % 4), 1'b1);
        chk_mem("R8 remove zeroes");
        for (int i = 0; i < N; i++) find("R8 R6 after remove", fill_handle(i), 5'(i % 4), 1'b0);

        clear_all();

        // R1 R4: colliding chains; k*33 folds to zero, with wrap near the end
        for (int k = 1; k <= 6; k++) ins("R1 R4 chain", 32'(k * 33), 5'd0, 2'd1, 20'(k), 1'b0);
        for (int k = 2; k <= 4; k++) ins("R1 R4 wrap", 32'(k * 33) ^ 32'd1, 5'd15, 2'd2, 20'(k + 40), 1'b1);
        chk_mem("R4 chain layout");
        for (int k = 1; k <= 6; k++) find("R6 chain hit", 32'(k * 33), 5'd0, 1'b0);
        for (int k = 2; k <= 4; k++) find("R6 wrap hit", 32'(k * 33) ^ 32'd1, 5'd15, 1'b0);
        find("R8 remove mid chain", 32'd66, 5'd0, 1'b1);
        find("R8 gap ends probe", 32'd99, 5'd0, 1'b0);
        find("R6 miss on empty", 32'd231, 5'd0, 1'b0);
        chk_mem("R8 chain after remove");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            vectors++;
            $display("FAIL R10: watchdog expired, got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule